// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the running status of a single channel of a USB device DMA engine. It watches control writes from software (run bit, chain-to-next bit, starting byte count), descriptor loads from a fetch engine, data beats, packet and transfer events from the endpoint, grants from the channel arbiter and the FIFO-empty level. From these it maintains a run flag, a busy (active) flag, three sticky event flags and the remaining byte count, and presents them as one 32-bit word on a read port.

Software polls the word. Reading it clears the three event flags, and an event arriving in the same cycle as the read is kept. A stop request does not take effect while a packet is still in flight with data in the FIFO: the run flag stays set until the FIFO has drained. When the run flag falls with the chain bit set, the block raises a one-cycle request for the next descriptor. An instance built with channel index 0 reads all zeros and never requests a descriptor.

Top module: `dma_chan_status`

## Requirements
- R1: Status word fields: bit 0 run, bit 1 busy, bit 4 transfer-ended-by-device, bit 5 buffer-exhausted, bit 6 descriptor-loaded, bits 31:16 remaining byte count. Bits 2, 3 and 7 to 15 are always zero.
- R2: After reset the status word is zero and `next_desc_req` is low.
- R3: A control write (`cw_stb`) loads the run bit, the chain bit and the byte count. A descriptor load (`dl_stb`) loads the same three values and sets bit 6. A control write takes priority.
- R4: While the run flag is set, each beat (`beat_vld`) lowers the count by `beat_bytes`, saturating at zero. Beats have no effect while the run flag is clear.
- R5: A beat that brings a non-zero count to zero sets bit 5 and clears the run flag on the next edge.
- R6: `dev_end` while running sets bit 4 and clears both the run and busy flags on the next edge.
- R7: A control write with run = 0, while the channel is busy and `fifo_empty` is low, leaves the run flag set until `fifo_empty` is seen high; the flag clears at that edge. When the channel is idle or the FIFO is empty, the run flag clears at the edge of the write.
- R8: `grant` while running sets the busy flag and `pkt_done` clears it. Buffer exhaustion leaves it set. A descriptor load with run = 1 keeps it, and a descriptor load with run = 0 clears it.
- R9: `rd_stb` clears bits 4, 5 and 6 at its edge, and `rd_data` shows the flags in the read cycle. An event that sets a flag in the same cycle as the read leaves that flag set.
- R10: `next_desc_req` is high for exactly one cycle, the cycle after the edge at which the run flag falls, if and only if the chain bit is set.
- R11: With CHAN_IDX = 0, `rd_data` is always zero and `next_desc_req` is always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_stb | input | 1 | Control write strobe |
| cw_run | input | 1 | Run bit of the control write |
| cw_chain | input | 1 | Chain-to-next-descriptor bit of the control write |
| cw_count | input | 16 | Byte count of the control write |
| dl_stb | input | 1 | Descriptor loaded strobe |
| dl_run | input | 1 | Run bit from the descriptor |
| dl_chain | input | 1 | Chain bit from the descriptor |
| dl_count | input | 16 | Byte count from the descriptor |
| beat_vld | input | 1 | Data beat moved |
| beat_bytes | input | BEAT_W | Bytes moved by the beat |
| grant | input | 1 | Channel selected to source packet data |
| pkt_done | input | 1 | Packet transfer finished |
| dev_end | input | 1 | Device ended the transfer |
| fifo_empty | input | 1 | DMA FIFO is empty |
| rd_stb | input | 1 | Status read strobe |
| rd_data | output | 32 | Status word |
| next_desc_req | output | 1 | One-cycle request for the next descriptor |

## Verification
The case that matters most is a status read falling in the same cycle as an event that sets a sticky flag. The bench provokes it twice: a read together with the beat that exhausts the buffer, and a read together with a descriptor load. Both times it expects the new flag to remain set after the edge, and then expects a second, quiet read to clear it. A second overlap, a stop request while a packet is in flight, is judged by holding `fifo_empty` low for several cycles and watching the run bit stay set until the FIFO drains.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned POS_RUN = 0;
  localparam int unsigned POS_BSY = 1;
  localparam int unsigned POS_ETR = 4;
  localparam int unsigned POS_EBF = 5;
  localparam int unsigned POS_DSC = 6;
  localparam int unsigned POS_CNT = 16;

  typedef struct packed {
    logic run;
    logic bsy;
    logic etr;
    logic ebf;
    logic dsc;
  } dcs_flags_t;
endpackage

// File: rtl/dcs_byte_counter.sv
module dcs_byte_counter
  import dcs_pkg::*;
#(
  parameter int unsigned BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ctl,
  input  logic [CNT_W-1:0]  ctl_val,
  input  logic              ld_dsc,
  input  logic [CNT_W-1:0]  dsc_val,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              run,
  output logic [CNT_W-1:0]  cnt,
  output logic              zero_evt
);
  localparam int unsigned PAD_W = CNT_W - BEAT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, beat_ext;
  logic             cnt_ce;

  assign beat_ext = {{PAD_W{1'b0}}, beat_bytes};
  assign cnt_ce   = ld_ctl | ld_dsc | (beat_vld & run);

  always_comb begin
    cnt_d    = cnt_q;
    zero_evt = 1'b0;
    if (ld_ctl) begin
      cnt_d = ctl_val;
    end else if (ld_dsc) begin
      cnt_d = dsc_val;
    end else if (beat_vld && run && (cnt_q != '0)) begin
      if (beat_ext >= cnt_q) begin
        cnt_d    = '0;
        zero_evt = 1'b1;
      end else begin
        cnt_d = cnt_q - beat_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dcs_flag_ctrl.sv
module dcs_flag_ctrl
  import dcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cw_stb,
  input  logic       cw_run,
  input  logic       cw_chain,
  input  logic       dl_stb,
  input  logic       dl_run,
  input  logic       dl_chain,
  input  logic       grant,
  input  logic       pkt_done,
  input  logic       dev_end,
  input  logic       fifo_empty,
  input  logic       zero_evt,
  input  logic       rd_clr,
  output dcs_flags_t flags,
  output logic       fetch_req
);
  dcs_flags_t fl_q, fl_d;
  logic       drain_q, drain_d;
  logic       chain_q, chain_d;
  logic       fetch_q, fetch_d;
  logic       dev_evt, stop_busy, fl_ce;

  assign dev_evt   = fl_q.run & dev_end;
  assign stop_busy = cw_stb & ~cw_run & fl_q.bsy & ~fifo_empty;
  assign fl_ce     = cw_stb | dl_stb | grant | pkt_done | dev_end | fifo_empty
                   | zero_evt | rd_clr | drain_q | fetch_q;

  always_comb begin
    fl_d    = fl_q;
    drain_d = drain_q;
    chain_d = chain_q;

    // run flag: end events, then descriptor, then control write
    if (zero_evt || dev_evt || (drain_q && fifo_empty)) fl_d.run = 1'b0;
    if (dl_stb) fl_d.run = dl_run;
    if (cw_stb) begin
      if (cw_run)         fl_d.run = 1'b1;
      else if (!stop_busy) fl_d.run = 1'b0;
    end

    if (stop_busy && fl_q.run) drain_d = 1'b1;
    if (!fl_d.run)             drain_d = 1'b0;

    // busy flag
    if (grant && fl_q.run)          fl_d.bsy = 1'b1;
    if (pkt_done || dev_evt)        fl_d.bsy = 1'b0;
    if (dl_stb && !dl_run)          fl_d.bsy = 1'b0;

    // sticky event flags, set beats clear
    fl_d.etr = (fl_q.etr & ~rd_clr) | dev_evt;
    fl_d.ebf = (fl_q.ebf & ~rd_clr) | zero_evt;
    fl_d.dsc = (fl_q.dsc & ~rd_clr) | dl_stb;

    if (cw_stb)      chain_d = cw_chain;
    else if (dl_stb) chain_d = dl_chain;

    fetch_d = fl_q.run & ~fl_d.run & chain_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q    <= '0;
      drain_q <= 1'b0;
      chain_q <= 1'b0;
    end else if (fl_ce) begin
      fl_q    <= fl_d;
      drain_q <= drain_d;
      chain_q <= chain_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fetch_q <= 1'b0;
    else        fetch_q <= fetch_d;
  end

  assign flags     = fl_q;
  assign fetch_req = fetch_q;
endmodule

// File: rtl/dcs_status_pack.sv
module dcs_status_pack
  import dcs_pkg::*;
#(
  parameter bit LIVE = 1'b1
) (
  input  dcs_flags_t        flags,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              fetch_in,
  output logic [WORD_W-1:0] word,
  output logic              fetch_out
);
  logic [WORD_W-1:0] raw;

  always_comb begin
    raw                          = '0;
    raw[POS_RUN]                 = flags.run;
    raw[POS_BSY]                 = flags.bsy;
    raw[POS_ETR]                 = flags.etr;
    raw[POS_EBF]                 = flags.ebf;
    raw[POS_DSC]                 = flags.dsc;
    raw[POS_CNT +: CNT_W]        = cnt;
  end

  generate
    if (LIVE) begin : g_live
      assign word      = raw;
      assign fetch_out = fetch_in;
    end else begin : g_dead
      logic unused_ok;
      assign unused_ok = ^{raw, fetch_in};
      assign word      = '0;
      assign fetch_out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dcs_pkg::*;
#(
  parameter int unsigned CHAN_IDX = 1,
  parameter int unsigned BEAT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cw_stb,
  input  logic              cw_run,
  input  logic              cw_chain,
  input  logic [15:0]       cw_count,
  input  logic              dl_stb,
  input  logic              dl_run,
  input  logic              dl_chain,
  input  logic [15:0]       dl_count,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              grant,
  input  logic              pkt_done,
  input  logic              dev_end,
  input  logic              fifo_empty,
  input  logic              rd_stb,
  output logic [31:0]       rd_data,
  output logic              next_desc_req
);
  localparam bit LIVE = (CHAN_IDX != 0);

  dcs_flags_t       flags;
  logic [CNT_W-1:0] cnt;
  logic             zero_evt, fetch_raw;

  dcs_byte_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .ld_ctl(cw_stb), .ctl_val(cw_count),
    .ld_dsc(dl_stb), .dsc_val(dl_count),
    .beat_vld(beat_vld), .beat_bytes(beat_bytes),
    .run(flags.run), .cnt(cnt), .zero_evt(zero_evt)
  );

  dcs_flag_ctrl u_flg (
    .clk(clk), .rst_n(rst_n),
    .cw_stb(cw_stb), .cw_run(cw_run), .cw_chain(cw_chain),
    .dl_stb(dl_stb), .dl_run(dl_run), .dl_chain(dl_chain),
    .grant(grant), .pkt_done(pkt_done), .dev_end(dev_end),
    .fifo_empty(fifo_empty), .zero_evt(zero_evt), .rd_clr(rd_stb),
    .flags(flags), .fetch_req(fetch_raw)
  );

  dcs_status_pack #(.LIVE(LIVE)) u_pack (
    .flags(flags), .cnt(cnt), .fetch_in(fetch_raw),
    .word(rd_data), .fetch_out(next_desc_req)
  );
endmodule

// File: rtl/dcs_status_chk.sv
module dcs_status_chk #(
  parameter int unsigned CHAN_IDX = 1,
  parameter int unsigned BEAT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cw_stb,
  input logic              dl_stb,
  input logic              beat_vld,
  input logic [BEAT_W-1:0] beat_bytes,
  input logic              pkt_done,
  input logic              dev_end,
  input logic              fifo_empty,
  input logic              rd_stb,
  input logic [31:0]       rd_data,
  input logic              next_desc_req
);
  logic [15:0] beat_w;
  assign beat_w = {{(16-BEAT_W){1'b0}}, beat_bytes};

  generate
    if (CHAN_IDX != 0) begin : g_live
      a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15:7] == '0) && (rd_data[3:2] == '0));

      a_r5_exhaust: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld && rd_data[0] && (rd_data[31:16] != '0) && (beat_w >= rd_data[31:16])
        && !cw_stb && !dl_stb
        |=> rd_data[5] && (rd_data[31:16] == '0) && !rd_data[0]);

      a_r6_dev_end: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && dev_end && !cw_stb && !dl_stb
        |=> !rd_data[0] && !rd_data[1] && rd_data[4]);

      a_r7_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] && !fifo_empty && !cw_stb && !dl_stb && !dev_end && !beat_vld
        |=> rd_data[0]);

      a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1] && !pkt_done && !dev_end && !dl_stb
        |=> rd_data[1]);

      a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !beat_vld && !dev_end && !dl_stb
        |=> (rd_data[6:4] == 3'b000));

      a_r10_fetch_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        next_desc_req |-> $past(rd_data[0]) && !rd_data[0]);
    end else begin : g_dead
      a_r11_chan0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data == '0) && !next_desc_req);
    end
  endgenerate
endmodule

bind dma_chan_status dcs_status_chk #(.CHAN_IDX(CHAN_IDX), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cw_stb(cw_stb), .dl_stb(dl_stb),
  .beat_vld(beat_vld), .beat_bytes(beat_bytes), .pkt_done(pkt_done),
  .dev_end(dev_end), .fifo_empty(fifo_empty), .rd_stb(rd_stb),
  .rd_data(rd_data), .next_desc_req(next_desc_req)
);

// File: tb/sim_dma_chan_status.sv
`timescale 1ns/1ps
module sim_dma_chan_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cw_stb = 0, cw_run = 0, cw_chain = 0;
  logic [15:0] cw_count = '0;
  logic        dl_stb = 0, dl_run = 0, dl_chain = 0;
  logic [15:0] dl_count = '0;
  logic        beat_vld = 0;
  logic [3:0]  beat_bytes = '0;
  logic        grant = 0, pkt_done = 0, dev_end = 0, fifo_empty = 1, rd_stb = 0;
  logic [31:0] rd_data, rd_data0;
  logic        next_desc_req, next_desc_req0;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  dma_chan_status #(.CHAN_IDX(1), .BEAT_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cw_stb(cw_stb), .cw_run(cw_run), .cw_chain(cw_chain),
    .cw_count(cw_count), .dl_stb(dl_stb), .dl_run(dl_run), .dl_chain(dl_chain),
    .dl_count(dl_count), .beat_vld(beat_vld), .beat_bytes(beat_bytes), .grant(grant),
    .pkt_done(pkt_done), .dev_end(dev_end), .fifo_empty(fifo_empty), .rd_stb(rd_stb),
    .rd_data(rd_data), .next_desc_req(next_desc_req)
  );

  dma_chan_status #(.CHAN_IDX(0), .BEAT_W(4)) u1 (
    .clk(clk), .rst_n(rst_n), .cw_stb(cw_stb), .cw_run(cw_run), .cw_chain(cw_chain),
    .cw_count(cw_count), .dl_stb(dl_stb), .dl_run(dl_run), .dl_chain(dl_chain),
    .dl_count(dl_count), .beat_vld(beat_vld), .beat_bytes(beat_bytes), .grant(grant),
    .pkt_done(pkt_done), .dev_end(dev_end), .fifo_empty(fifo_empty), .rd_stb(rd_stb),
    .rd_data(rd_data0), .next_desc_req(next_desc_req0)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cw_stb = 0; dl_stb = 0; beat_vld = 0; grant = 0;
    pkt_done = 0; dev_end = 0; rd_stb = 0;
  endtask

  task automatic ctl(input logic run, input logic chain, input logic [15:0] n);
    cw_stb = 1; cw_run = run; cw_chain = chain; cw_count = n; cyc();
  endtask

  task automatic dload(input logic run, input logic chain, input logic [15:0] n);
    dl_stb = 1; dl_run = run; dl_chain = chain; dl_count = n; cyc();
  endtask

  task automatic beat(input logic [3:0] b);
    beat_vld = 1; beat_bytes = b; cyc();
  endtask

  task automatic rd();
    rd_stb = 1; cyc();
  endtask

  task automatic t_reset();
    chk("R2 status word", rd_data, 32'h0);
    chk("R2 next_desc_req", {31'b0, next_desc_req}, 32'h0);
    chk("R11 chan0 at reset", rd_data0, 32'h0);
  endtask

  task automatic t_count();
    ctl(1, 0, 16'd100);
    chk("R3 control load", rd_data, 32'h0064_0001);
    beat(4'd7);
    chk("R4 decrement 7", rd_data, 32'h005D_0001);
    beat(4'd15);
    chk("R4 decrement 15 / R1 layout", rd_data, 32'h004E_0001);
    ctl(0, 0, 16'd78);
    chk("R7 idle stop", rd_data, 32'h004E_0000);
    beat(4'd3);
    chk("R4 beat ignored when stopped", rd_data, 32'h004E_0000);
  endtask

  task automatic t_exhaust();
    ctl(1, 0, 16'd10);
    grant = 1; cyc();
    chk("R8 grant sets busy", rd_data, 32'h000A_0003);
    beat(4'd7);
    chk("R4 partial", rd_data, 32'h0003_0003);
    beat(4'd15);
    chk("R5 saturate, buffer flag, run off, busy kept", rd_data, 32'h0000_0022);
    chk("R10 no request without chain", {31'b0, next_desc_req}, 32'h0);
    dload(1, 0, 16'd50);
    chk("R8 busy survives reload / R3 desc flag", rd_data, 32'h0032_0063);
    pkt_done = 1; cyc();
    chk("R8 pkt_done clears busy", rd_data, 32'h0032_0061);
    rd_stb = 1;
    #1;
    chk("R9 flags visible in read cycle", rd_data, 32'h0032_0061);
    cyc();
    chk("R9 read clears event flags", rd_data, 32'h0032_0001);
    ctl(0, 0, 16'd0);
  endtask

  task automatic t_dev_end();
    ctl(1, 1, 16'd200);
    grant = 1; cyc();
    dev_end = 1; cyc();
    chk("R6 device end", rd_data, 32'h00C8_0010);
    chk("R10 request pulse", {31'b0, next_desc_req}, 32'h1);
    cyc();
    chk("R10 request one cycle", {31'b0, next_desc_req}, 32'h0);
    rd();
    chk("R9 clear transfer flag", rd_data, 32'h00C8_0000);
  endtask

  task automatic t_drain();
    ctl(1, 0, 16'd30);
    grant = 1; cyc();
    fifo_empty = 0;
    ctl(0, 0, 16'd30);
    chk("R7 run held while draining", rd_data, 32'h001E_0003);
    cyc(); cyc();
    chk("R7 still held", rd_data, 32'h001E_0003);
    fifo_empty = 1; cyc();
    chk("R7 run drops on drain", rd_data, 32'h001E_0002);
    dload(0, 0, 16'd9);
    chk("R8 stopped reload clears busy", rd_data, 32'h0009_0040);
    rd();
    chk("R9 clear desc flag", rd_data, 32'h0009_0000);
  endtask

  task automatic t_overlap();
    ctl(1, 0, 16'd5);
    beat_vld = 1; beat_bytes = 4'd5; rd_stb = 1; cyc();
    chk("R9 set wins over read (buffer)", rd_data, 32'h0000_0020);
    rd();
    chk("R9 quiet read clears", rd_data, 32'h0);
    dl_stb = 1; dl_run = 0; dl_chain = 0; dl_count = 16'd0; rd_stb = 1; cyc();
    chk("R9 set wins over read (desc)", rd_data, 32'h0000_0040);
    rd();
    chk("R9 final clear", rd_data, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_exhaust();
    t_dev_end();
    t_drain();
    t_overlap();
    chk("R11 chan0 word", rd_data0, 32'h0);
    chk("R11 chan0 request", {31'b0, next_desc_req0}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic r11_seen = 1'b0;
  always @(negedge clk)
    if (rst_n && ((rd_data0 != 0) || next_desc_req0) && !r11_seen) begin
      r11_seen = 1'b1;
      total++; bad++;
      $display("FAIL R11: chan0 active got %08h expected 00000000", rd_data0);
    end

  initial begin
    #20000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule